// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the pending-flag register and the enable-mask register of a general-purpose peripheral with two timers and a shift unit. It drives one level-sensitive interrupt line. Single-cycle pulses from the timers and the shift logic set flag bits. Host byte accesses clear them: a write to the flag register clears the bits written as 1. Reads of the shift-data and timer low-count registers clear the flags that belong to those units. The host can set or clear enable bits through a single write to the enable register.

Each host access is a one-cycle strobe and is always accepted, so there is no back-pressure. The register index comes from byte-address bits 12 to 9. Read data is combinational from the current register state, and any clear caused by a read takes effect at the end of that access cycle. The interrupt output is decoded from the registered flags and enables. The timer counters and the shift transfer logic sit outside this block.

Top module: `intr_flag_enable`

## Requirements
- R1: After reset, every flag and enable bit is 0, the interrupt output is low, a flag read returns 0x00 and an enable read returns 0x80.
- R2: Each event input sets its own flag bit one clock after its pulse: shift-done sets bit 2, shift-data bit 3, shift-clock bit 4, timer 2 bit 5 and timer 1 bit 6. Bits 1 and 0 always read 0.
- R3: A write to the enable register (index 14) with bit 7 = 1 sets every enable bit whose written bit in 6..0 is 1 and leaves the other enable bits unchanged.
- R4: A write to the enable register with bit 7 = 0 clears every enable bit whose written bit in 6..0 is 1 and leaves the other enable bits unchanged.
- R5: A write to the flag register (index 13) clears every flag bit written as 1 and leaves the flag bits written as 0 unchanged.
- R6: A flag read returns the flags in bits 6..0. Bit 7 is 1 exactly when some bit is set in both flags and enables, and this includes bits 3 and 4.
- R7: An enable read returns the enable mask in bits 6..0 with bit 7 always 1.
- R8: The interrupt output is high exactly when flag AND enable is nonzero in bit 2, bit 5 or bit 6. Enabled pending bits 3 and 4 never raise it.
- R9: A read of index 10 (shift data) clears flags 2, 3 and 4. A read of index 4 (timer 1 low count) clears flag 6. A read of index 8 (timer 2 low count) clears flag 5. Each clear happens after the read cycle.
- R10: Accesses to indices other than 13 and 14 read 0x00. Writes to them change neither register, apart from the read clears of R9.
- R11: When an event pulse and a clear (flag write or clearing read) hit the same flag bit in the same cycle, the bit ends up set.
- R12: The interrupt output changes in the clock cycle after the event or access that changes the flags or enables, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Host byte access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte-address bits 12..9, the register index |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current access, 0x00 for indices other than 13 and 14 |
| evt_sh_done | input | 1 | Shift-register done pulse |
| evt_sh_data | input | 1 | Shift data pulse |
| evt_sh_clk | input | 1 | Shift clock pulse |
| evt_t2 | input | 1 | Timer 2 pulse |
| evt_t1 | input | 1 | Timer 1 pulse |
| irq | output | 1 | Level interrupt request |

## Verification
An event pulse and a host clear of the same flag bit can land in the same cycle. The clear may come from a flag-register write or from a read of the shift or timer low-count register. The bench provokes this collision by driving the event pin and the access strobe on the same clock edge. It then reads the flag register and expects the bit still set, with the interrupt still asserted when the bit is enabled. It also checks the same clears with no event present, where the bit must fall.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int FLAG_W   = 7;
  localparam int IDX_W    = 4;
  localparam int B_SHDONE = 2;
  localparam int B_SHDATA = 3;
  localparam int B_SHCLK  = 4;
  localparam int B_T2     = 5;
  localparam int B_T1     = 6;

  localparam logic [FLAG_W-1:0] SRC_MASK = (FLAG_W'(1) << B_SHDONE) | (FLAG_W'(1) << B_SHDATA)
                                         | (FLAG_W'(1) << B_SHCLK)  | (FLAG_W'(1) << B_T2)
                                         | (FLAG_W'(1) << B_T1);
  localparam logic [FLAG_W-1:0] IRQ_MASK = (FLAG_W'(1) << B_SHDONE) | (FLAG_W'(1) << B_T2)
                                         | (FLAG_W'(1) << B_T1);
  localparam logic [FLAG_W-1:0] SHIFT_GRP = (FLAG_W'(1) << B_SHDONE) | (FLAG_W'(1) << B_SHDATA)
                                          | (FLAG_W'(1) << B_SHCLK);

  localparam logic [IDX_W-1:0] IDX_FLAG  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_EN    = 4'd14;
  localparam logic [IDX_W-1:0] IDX_SHIFT = 4'd10;
  localparam logic [IDX_W-1:0] IDX_T1LO  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_T2LO  = 4'd8;

  typedef struct packed {
    logic rd_flag;
    logic rd_en;
    logic wr_flag;
    logic wr_en;
    logic rd_shift;
    logic rd_t1;
    logic rd_t2;
  } acc_dec_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
(
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] idx,
  output acc_dec_t         dec
);
  logic rd, wr;
  assign rd = acc_en & ~acc_wr;
  assign wr = acc_en & acc_wr;

  always_comb begin
    dec          = '0;
    dec.rd_flag  = rd && (idx == IDX_FLAG);
    dec.rd_en    = rd && (idx == IDX_EN);
    dec.wr_flag  = wr && (idx == IDX_FLAG);
    dec.wr_en    = wr && (idx == IDX_EN);
    dec.rd_shift = rd && (idx == IDX_SHIFT);
    dec.rd_t1    = rd && (idx == IDX_T1LO);
    dec.rd_t2    = rd && (idx == IDX_T2LO);
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
#(
  parameter int W = FLAG_W,
  parameter logic [W-1:0] PRESENT = SRC_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PRESENT[i]) begin : g_reg
      logic r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= 1'b0;
        else        r <= (r & ~clr_vec[i]) | set_vec[i];
      end
      assign q[i] = r;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> q[i]); // R11
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !set_vec[i]) |=> !q[i]); // R5
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
  import irqc_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W:0]   wdata,
  output logic [W-1:0] q
);
  logic         mode_set;
  logic [W-1:0] sel;
  assign mode_set = wdata[W];
  assign sel      = wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (wr) begin
      if (mode_set)   q <= q | sel;
      else            q <= q & ~sel;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[W]) |=> ((q & $past(wdata[W-1:0])) == $past(wdata[W-1:0]))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[W]) |=> ((q & $past(wdata[W-1:0])) == '0)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R10
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] enables,
  input  acc_dec_t          dec,
  output logic [7:0]        rdata,
  output logic              irq
);
  logic [FLAG_W-1:0] live;
  logic              pend_any;

  assign live     = flags & enables;
  assign pend_any = |live;
  assign irq      = |(live & IRQ_MASK);

  always_comb begin
    rdata = 8'h00;
    if (dec.rd_flag)     rdata = {pend_any, flags};
    else if (dec.rd_en)  rdata = {1'b1, enables};
  end

  AST_IRQ_IN_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.rd_flag && irq) |-> rdata[7]); // R6
  AST_EN_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec.rd_en |-> rdata[7]); // R7
  AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[B_SHDONE] || flags[B_T2] || flags[B_T1])); // R8
endmodule

// File: rtl/intr_flag_enable.sv
module intr_flag_enable
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [3:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       evt_sh_done,
  input  logic       evt_sh_data,
  input  logic       evt_sh_clk,
  input  logic       evt_t2,
  input  logic       evt_t1,
  output logic       irq
);
  acc_dec_t          dec;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags, enables;

  irqc_decode u_dec (
    .acc_en (acc_en),
    .acc_wr (acc_wr),
    .idx    (acc_addr),
    .dec    (dec)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_SHDONE] = evt_sh_done;
    set_vec[B_SHDATA] = evt_sh_data;
    set_vec[B_SHCLK]  = evt_sh_clk;
    set_vec[B_T2]     = evt_t2;
    set_vec[B_T1]     = evt_t1;
  end

  always_comb begin
    clr_vec = '0;
    if (dec.wr_flag)  clr_vec = clr_vec | acc_wdata[FLAG_W-1:0];
    if (dec.rd_shift) clr_vec = clr_vec | SHIFT_GRP;
    if (dec.rd_t1)    clr_vec[B_T1] = 1'b1;
    if (dec.rd_t2)    clr_vec[B_T2] = 1'b1;
  end

  irqc_flags #(.W(FLAG_W), .PRESENT(SRC_MASK)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (flags)
  );

  irqc_enable #(.W(FLAG_W)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (dec.wr_en),
    .wdata (acc_wdata),
    .q     (enables)
  );

  irqc_readback u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .enables (enables),
    .dec     (dec),
    .rdata   (acc_rdata),
    .irq     (irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!irq && flags == '0 && enables == '0)); // R1
  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(|(set_vec & IRQ_MASK)) && !dec.wr_en) |=> !irq); // R12
endmodule

// File: tb/sim_intr_flag_enable.sv
module sim_intr_flag_enable;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0;
  logic [3:0] acc_addr = 4'd0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       evt_sh_done = 1'b0, evt_sh_data = 1'b0, evt_sh_clk = 1'b0;
  logic       evt_t2 = 1'b0, evt_t1 = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  intr_flag_enable u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .evt_sh_done(evt_sh_done), .evt_sh_data(evt_sh_data), .evt_sh_clk(evt_sh_clk),
    .evt_t2(evt_t2), .evt_t1(evt_t1), .irq(irq)
  );

  localparam logic [3:0] I_FLAG = 4'd13, I_EN = 4'd14;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // One cycle: access and/or event mask (bit positions as flags). Returns read data.
  task automatic cyc(input logic en, input logic wr, input logic [3:0] idx,
                     input logic [7:0] wd, input logic [7:0] ev, output logic [7:0] rd);
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = idx; acc_wdata = wd;
    evt_sh_done = ev[2]; evt_sh_data = ev[3]; evt_sh_clk = ev[4];
    evt_t2 = ev[5]; evt_t1 = ev[6];
    #1 rd = acc_rdata;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; acc_wdata = 8'h00;
    evt_sh_done = 0; evt_sh_data = 0; evt_sh_clk = 0; evt_t2 = 0; evt_t1 = 0;
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
    logic [7:0] x; cyc(1, 1, idx, d, 8'h00, x);
  endtask
  task automatic rd_reg(input logic [3:0] idx, output logic [7:0] d);
    cyc(1, 0, idx, 8'h00, 8'h00, d);
  endtask
  task automatic pulse(input logic [7:0] ev);
    logic [7:0] x; cyc(0, 0, 4'd0, 8'h00, ev, x);
  endtask
  task automatic wipe();
    wr_reg(I_FLAG, 8'h7F); wr_reg(I_EN, 8'h7F);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd_reg(I_FLAG, d); chk("R1 flag reset", d, 8'h00);
    rd_reg(I_EN, d);   chk("R1/R7 enable reset", d, 8'h80);
  endtask

  task automatic t_events();
    logic [7:0] d;
    for (int b = 2; b <= 6; b++) begin
      pulse(8'(1 << b));
      rd_reg(I_FLAG, d); chk("R2 event sets flag", d, 8'(1 << b));
      wr_reg(I_FLAG, 8'(1 << b));
      rd_reg(I_FLAG, d); chk("R5 flag write clears", d, 8'h00);
    end
    pulse(8'h7C);
    wr_reg(I_FLAG, 8'h14);
    rd_reg(I_FLAG, d); chk("R5 zero bits kept", d, 8'h68);
    wipe();
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr_reg(I_EN, 8'hE4); rd_reg(I_EN, d); chk("R3 enable set", d, 8'hE4);
    wr_reg(I_EN, 8'h04); rd_reg(I_EN, d); chk("R4 enable clear", d, 8'hE0);
    wr_reg(I_EN, 8'h81); rd_reg(I_EN, d); chk("R3 enable set keeps others", d, 8'hE1);
    wr_reg(I_EN, 8'h7F); rd_reg(I_EN, d); chk("R7 enable bit7 with empty mask", d, 8'h80);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr_reg(I_EN, 8'h98);
    pulse(8'h08);
    rd_reg(I_FLAG, d); chk("R6 summary on shift-data", d, 8'h88);
    chk("R8 shift-data no irq", {7'd0, irq}, 8'h00);
    pulse(8'h10);
    chk("R8 shift-clock no irq", {7'd0, irq}, 8'h00);
    wr_reg(I_EN, 8'hA0);
    pulse(8'h20);
    chk("R8 timer2 irq", {7'd0, irq}, 8'h01);
    rd_reg(I_FLAG, d); chk("R6 flag read", d, 8'hB8);
    wr_reg(I_FLAG, 8'h20);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    wr_reg(I_EN, 8'h18);
    rd_reg(I_FLAG, d); chk("R6 no summary when disabled", d, 8'h18);
    wr_reg(I_EN, 8'hC4);
    pulse(8'h04);
    chk("R8 shift-done irq", {7'd0, irq}, 8'h01);
    wipe();
  endtask

  task automatic t_timing();
    wr_reg(I_EN, 8'hC0);
    @(negedge clk); evt_t1 = 1;
    #1 chk("R12 irq not same cycle", {7'd0, irq}, 8'h00);
    @(negedge clk); evt_t1 = 0;
    chk("R12 irq next cycle", {7'd0, irq}, 8'h01);
    wipe();
  endtask

  task automatic t_rdclr();
    logic [7:0] d;
    pulse(8'h7C);
    rd_reg(4'd10, d); chk("R10 shift index reads zero", d, 8'h00);
    rd_reg(I_FLAG, d); chk("R9 shift read clears 2..4", d, 8'h60);
    rd_reg(4'd4, d);
    rd_reg(I_FLAG, d); chk("R9 timer1 read clears", d, 8'h20);
    rd_reg(4'd8, d);
    rd_reg(I_FLAG, d); chk("R9 timer2 read clears", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr_reg(I_EN, 8'hC0);
    pulse(8'h40);
    cyc(1, 1, I_FLAG, 8'h40, 8'h40, d);
    rd_reg(I_FLAG, d); chk("R11 set beats flag write", d, 8'hC0);
    chk("R11 irq held", {7'd0, irq}, 8'h01);
    cyc(1, 0, 4'd4, 8'h00, 8'h40, d);
    rd_reg(I_FLAG, d); chk("R11 set beats read clear", d, 8'hC0);
    pulse(8'h1C);
    cyc(1, 0, 4'd10, 8'h00, 8'h08, d);
    rd_reg(I_FLAG, d); chk("R11 shift read with data event", d, 8'hC8);
    wipe();
  endtask

  task automatic t_decode();
    logic [7:0] d;
    pulse(8'h24);
    wr_reg(4'd12, 8'hFF); wr_reg(4'd15, 8'hFF); wr_reg(4'd5, 8'h7F);
    rd_reg(I_EN, d);   chk("R10 other writes leave enable", d, 8'h80);
    rd_reg(I_FLAG, d); chk("R10 other writes leave flags", d, 8'h24);
    rd_reg(4'd3, d);   chk("R10 other index reads zero", d, 8'h00);
    rd_reg(I_FLAG, d); chk("R10 other read leaves flags", d, 8'h24);
    wipe();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_enable();
    t_irq();
    t_timing();
    t_rdclr();
    t_collide();
    t_decode();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule